// File: doc/BRIEF.md
# GPIO Controller with Configurable Pin Interrupts

A 32-pin general-purpose I/O block that sits behind a flat word-wide register interface. Software sets each pin as an input or an output. Output levels change only through two atomic ports: one raises every bit written as 1, the other lowers every bit written as 1. Pin levels pass through a two-stage synchroniser, and software can read the synchronised values back.

Each pin carries an interrupt detector. Three per-pin configuration words choose the mode: a method bit (edge or level), a both-edges bit and a polarity bit. Together they give five detection modes: rising, falling, both edges, active-high and active-low. Edge events are latched until software acknowledges them. Level conditions follow the pin directly. A masked status word combines the raw status with an enable word and a mask word. One combined interrupt line goes to the processor.

Writes happen on a single-cycle write strobe. Reads are combinational from the address. Register offsets: input 0x04, direction 0x08, set 0x10, clear 0x14, enable 0x20, raw status 0x24, masked status 0x28, mask 0x2C, acknowledge 0x30, method 0x34, both-edges 0x38, polarity 0x3C. Any other offset reads as zero.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, all pins are inputs (pin_oe_o = 0), pin_o = 0, irq_o = 0, and every writable configuration word reads 0.
- R2: A write to offset 0x10 drives pin_o high on every bit written as 1 and leaves the other bits unchanged. pin_o changes only on writes to 0x10 or 0x14.
- R3: A write to offset 0x14 drives pin_o low on every bit written as 1 and leaves the other bits unchanged.
- R4: The word at offset 0x08 drives pin_oe_o from the clock edge that writes it. A bit of 1 makes the pin an output.
- R5: Reading offset 0x04 returns pin_i after two register stages: a level applied before clock edge k reads back after edge k+1.
- R6: With method=0, both-edges=0 and polarity=0, a 0-to-1 transition of the synchronised pin sets the pin's bit in raw status (offset 0x24). A 1-to-0 transition does not set it.
- R7: With method=0, both-edges=0 and polarity=1, only a 1-to-0 transition sets the raw status bit.
- R8: With method=0 and both-edges=1, either transition sets the raw status bit.
- R9: With method=1, the raw status bit equals the synchronised pin level (polarity 0) or its inverse (polarity 1). It is not latched, and the acknowledge write does not change it.
- R10: Writing 1s to offset 0x30 clears the matching latched edge status bits. Bits written as 0 leave their status unchanged.
- R11: Masked status (offset 0x28) equals raw AND enable (0x20) AND NOT mask (0x2C). irq_o is 1 exactly when masked status is nonzero.
- R12: Offsets outside the register map read as 0, and writes to the read-only offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe, one word per asserted cycle |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| pin_i | input | 32 | Pad input levels (asynchronous) |
| pin_o | output | 32 | Output data toward the pads |
| pin_oe_o | output | 32 | Per-pin output enable |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its defaults: 32 pins on a 32-bit data bus. At that size the top lane, bit 31, reaches the set, clear and detection paths, and every register word has no unused bits. The directed scenarios place each detection mode on a different pin, so a mix-up between the method, both-edges and polarity words shows up as a wrong raw status bit. The synchroniser depth is checked by reading the input word one cycle too early and then again at the right cycle.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 8;
  localparam int BUS_W  = 32;

  localparam logic [ADDR_W-1:0] OFF_INPUT  = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_DIR    = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_SET    = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_CLR    = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_EN     = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_RAW    = 8'h24;
  localparam logic [ADDR_W-1:0] OFF_MSK_ST = 8'h28;
  localparam logic [ADDR_W-1:0] OFF_MASK   = 8'h2C;
  localparam logic [ADDR_W-1:0] OFF_ACK    = 8'h30;
  localparam logic [ADDR_W-1:0] OFF_METHOD = 8'h34;
  localparam logic [ADDR_W-1:0] OFF_BOTH   = 8'h38;
  localparam logic [ADDR_W-1:0] OFF_POL    = 8'h3C;

  typedef struct packed {
    logic level_mode;
    logic both_edges;
    logic polarity;
  } trig_cfg_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_trig_cell.sv
module gpio_trig_cell
  import gpio_irq_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      cur_i,
  input  trig_cfg_t cfg_i,
  input  logic      ack_i,
  output logic      raw_o
);
  logic prev_q, latch_q;
  logic rise, fall, hit;

  assign rise = cur_i & ~prev_q;
  assign fall = ~cur_i & prev_q;

  always_comb begin
    if (cfg_i.both_edges) hit = rise | fall;
    else if (cfg_i.polarity) hit = fall;
    else hit = rise;
  end

  // a new edge wins over a same-cycle acknowledge so no event is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      prev_q <= cur_i;
      if (!cfg_i.level_mode && hit) latch_q <= 1'b1;
      else if (ack_i)               latch_q <= 1'b0;
    end
  end

  assign raw_o = cfg_i.level_mode ? (cur_i ^ cfg_i.polarity) : latch_q;
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int N_PINS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  input  logic [N_PINS-1:0] pin_i,
  output logic [N_PINS-1:0] pin_o,
  output logic [N_PINS-1:0] pin_oe_o,
  output logic              irq_o
);
  localparam int PAD_W = BUS_W - N_PINS;

  logic [N_PINS-1:0] out_q, dir_q, en_q, mask_q;
  logic [N_PINS-1:0] method_q, both_q, pol_q;
  logic [N_PINS-1:0] pin_sync, raw_st, masked_st, wbits;
  logic wr_set, wr_clr, wr_ack;

  assign wbits  = wdata_i[N_PINS-1:0];
  assign wr_set = wr_en_i && (addr_i == OFF_SET);
  assign wr_clr = wr_en_i && (addr_i == OFF_CLR);
  assign wr_ack = wr_en_i && (addr_i == OFF_ACK);

  gpio_sync #(.WIDTH(N_PINS), .STAGES(2)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    trig_cfg_t cfg;
    assign cfg.level_mode = method_q[g];
    assign cfg.both_edges = both_q[g];
    assign cfg.polarity   = pol_q[g];

    gpio_trig_cell i_cell (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .cur_i (pin_sync[g]),
      .cfg_i (cfg),
      .ack_i (wr_ack && wbits[g]),
      .raw_o (raw_st[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q    <= '0;
      dir_q    <= '0;
      en_q     <= '0;
      mask_q   <= '0;
      method_q <= '0;
      both_q   <= '0;
      pol_q    <= '0;
    end else begin
      if (wr_set) out_q <= out_q | wbits;
      if (wr_clr) out_q <= out_q & ~wbits;
      if (wr_en_i) begin
        case (addr_i)
          OFF_DIR:    dir_q    <= wbits;
          OFF_EN:     en_q     <= wbits;
          OFF_MASK:   mask_q   <= wbits;
          OFF_METHOD: method_q <= wbits;
          OFF_BOTH:   both_q   <= wbits;
          OFF_POL:    pol_q    <= wbits;
          default: ;
        endcase
      end
    end
  end

  assign masked_st = raw_st & en_q & ~mask_q;
  assign irq_o     = |masked_st;
  assign pin_o     = out_q;
  assign pin_oe_o  = dir_q;

  logic [N_PINS-1:0] rd_word;
  always_comb begin
    case (addr_i)
      OFF_INPUT:  rd_word = pin_sync;
      OFF_DIR:    rd_word = dir_q;
      OFF_EN:     rd_word = en_q;
      OFF_RAW:    rd_word = raw_st;
      OFF_MSK_ST: rd_word = masked_st;
      OFF_MASK:   rd_word = mask_q;
      OFF_METHOD: rd_word = method_q;
      OFF_BOTH:   rd_word = both_q;
      OFF_POL:    rd_word = pol_q;
      default:    rd_word = '0;
    endcase
  end

  if (PAD_W > 0) begin : g_pad
    assign rdata_o = {{PAD_W{1'b0}}, rd_word};
  end else begin : g_nopad
    assign rdata_o = rd_word;
  end
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_irq_pkg::*;
#(
  parameter int N_PINS = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [BUS_W-1:0]  wdata_i,
  input logic [N_PINS-1:0] pin_o,
  input logic [N_PINS-1:0] pin_oe_o,
  input logic [N_PINS-1:0] mask_i,
  input logic              irq_o
);
  p_set_bits_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFF_SET) |=>
      ((pin_o & $past(wdata_i[N_PINS-1:0])) == $past(wdata_i[N_PINS-1:0])));

  p_out_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && (addr_i == OFF_SET || addr_i == OFF_CLR)) |=> $stable(pin_o));

  p_clr_bits_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFF_CLR) |=>
      ((pin_o & $past(wdata_i[N_PINS-1:0])) == '0));

  p_dir_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFF_DIR) |=> (pin_oe_o == $past(wdata_i[N_PINS-1:0])));

  p_mask_all_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_i) |-> !irq_o);
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.N_PINS(N_PINS)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .pin_o   (pin_o),
  .pin_oe_o(pin_oe_o),
  .mask_i  (mask_q),
  .irq_o   (irq_o)
);

// File: tb/test_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module test_gpio_irq_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [31:0] pin_i = '0;
  logic [31:0] pin_o, pin_oe_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;

  always #4 clk_i = ~clk_i;

  gpio_irq_ctrl i_gpio_irq_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .pin_i(pin_i), .pin_o(pin_o),
    .pin_oe_o(pin_oe_o), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic cleanup();
    wr(8'h34, '0); wr(8'h38, '0); wr(8'h3C, '0);
    wr(8'h20, '0); wr(8'h2C, '0);
    @(negedge clk_i); pin_i = '0;
    settle();
    wr(8'h30, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 oe", pin_oe_o, '0);
    check("R1 out", pin_o, '0);
    check("R1 irq", {31'b0, irq_o}, '0);
    foreach (v[i]) ;
    rd(8'h08, v); check("R1 dir", v, '0);
    rd(8'h34, v); check("R1 method", v, '0);
    rd(8'h2C, v); check("R1 mask", v, '0);
  endtask

  task automatic t_out();
    wr(8'h10, 32'h8000_00F0);
    check("R2 set", pin_o, 32'h8000_00F0);
    wr(8'h10, 32'h0000_0003);
    check("R2 set keep", pin_o, 32'h8000_00F3);
    wr(8'h20, 32'h1);
    check("R2 other write", pin_o, 32'h8000_00F3);
    wr(8'h14, 32'h8000_0010);
    check("R3 clear", pin_o, 32'h0000_00E3);
    wr(8'h14, 32'h0);
    check("R3 zero", pin_o, 32'h0000_00E3);
    wr(8'h08, 32'hA5A5_0001);
    check("R4 dir", pin_oe_o, 32'hA5A5_0001);
    wr(8'h08, 32'h0); wr(8'h20, 32'h0);
  endtask

  task automatic t_input();
    logic [31:0] v;
    @(negedge clk_i); pin_i = 32'h1234_5678; addr_i = 8'h04;
    @(posedge clk_i); @(negedge clk_i); #1;
    check("R5 early", rdata_o, 32'h0);
    @(posedge clk_i); @(negedge clk_i); #1;
    check("R5 input", rdata_o, 32'h1234_5678);
    @(negedge clk_i); pin_i = '0;
    settle();
    wr(8'h30, 32'hFFFF_FFFF);
    rd(8'h04, v); check("R5 zero", v, '0);
  endtask

  task automatic t_edges();
    logic [31:0] v;
    // pin 3 rising, pin 9 falling, pin 31 both
    wr(8'h3C, 32'h0000_0200);
    wr(8'h38, 32'h8000_0000);
    @(negedge clk_i); pin_i = 32'h0000_0200; settle();
    rd(8'h24, v); check("R7 no rise", v, 32'h0);
    @(negedge clk_i); pin_i = 32'h8000_0008; settle();
    rd(8'h24, v); check("R6 R7 R8 edge", v, 32'h8000_0208);
    wr(8'h30, 32'hFFFF_FFFF);
    rd(8'h24, v); check("R10 ack", v, 32'h0);
    @(negedge clk_i); pin_i = 32'h0000_0000; settle();
    rd(8'h24, v); check("R6 R8 fall", v, 32'h8000_0000);
    wr(8'h30, 32'h0);
    rd(8'h24, v); check("R10 zero ack", v, 32'h8000_0000);
    wr(8'h24, 32'h0); wr(8'h28, 32'h0);
    rd(8'h24, v); check("R12 ro write", v, 32'h8000_0000);
    rd(8'h40, v); check("R12 unmapped", v, 32'h0);
    cleanup();
  endtask

  task automatic t_level();
    logic [31:0] v;
    // pin 0 active-high, pin 1 active-low
    wr(8'h3C, 32'h2);
    wr(8'h34, 32'h3);
    settle();
    rd(8'h24, v); check("R9 idle", v, 32'h2);
    @(negedge clk_i); pin_i = 32'h3; settle();
    rd(8'h24, v); check("R9 track", v, 32'h1);
    wr(8'h30, 32'h3);
    rd(8'h24, v); check("R9 ack no effect", v, 32'h1);
    @(negedge clk_i); pin_i = 32'h0; settle();
    rd(8'h24, v); check("R9 unlatched", v, 32'h2);
    cleanup();
  endtask

  task automatic t_irq();
    logic [31:0] v;
    @(negedge clk_i); pin_i = 32'h20; settle();
    rd(8'h28, v); check("R11 no enable", v, 32'h0);
    check("R11 irq off", {31'b0, irq_o}, 32'h0);
    wr(8'h20, 32'h20);
    rd(8'h28, v); check("R11 masked", v, 32'h20);
    check("R11 irq on", {31'b0, irq_o}, 32'h1);
    wr(8'h2C, 32'h20);
    check("R11 irq masked", {31'b0, irq_o}, 32'h0);
    wr(8'h2C, 32'h0);
    check("R11 irq unmasked", {31'b0, irq_o}, 32'h1);
    wr(8'h30, 32'h20);
    check("R10 R11 irq cleared", {31'b0, irq_o}, 32'h0);
    cleanup();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_out();
    t_input();
    t_edges();
    t_level();
    t_irq();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule